// File: doc/BRIEF.md
# Wait-State Memory Read Controller

This block sits between a processor core and a slow external memory and carries out single read transfers for the core. The core presents an address with a valid/ready handshake. Once the controller accepts the request, it runs a fixed sequence of four clock cycles on the external bus:

- an address phase with the strobe inactive,
- two cycles with the active-low read strobe asserted, the second of which is a dead cycle that gives the memory time to answer,
- a final cycle in which the strobe is released.

The data bus is registered on the clock edge that releases the strobe. The captured word goes back to the core together with a single-cycle valid pulse.

The controller accepts a new request only while it is idle. Request inputs presented while a transfer is running have no effect. The address bus keeps the last address after a transfer ends, so the external bus does not toggle between reads. The fastest rate is therefore one read every five clock cycles.

Top module: `wait_read_ctrl`

## Requirements
- R1: While rst_n is low, and immediately after it falls (asynchronously, even in the middle of a transfer), req_ready is 1, mem_rd_n is 1, mem_addr is all zeros, rdata_valid is 0 and rdata is all zeros.
- R2: When req_valid and req_ready are both 1 at a rising clock edge, mem_addr equals the request address in the following cycle (phase 1), and mem_rd_n is still 1 in that cycle.
- R3: mem_rd_n is 0 in exactly two consecutive cycles per transfer, phases 2 and 3, and returns to 1 in phase 4.
- R4: mem_addr holds the accepted address without change from phase 1 through phase 4, and continues to hold it after the transfer until another request is accepted.
- R5: rdata takes the value present on mem_data at the rising edge that ends phase 3, which is the edge at which mem_rd_n returns to 1. The value of mem_data in any other cycle has no effect on rdata.
- R6: rdata_valid is 1 for exactly one cycle per transfer, in phase 4, while mem_rd_n is 1.
- R7: req_ready is 0 in phases 1 to 4. A req_valid raised during a transfer, with any address, neither starts a transfer nor changes mem_addr.
- R8: req_ready is 1 again in the cycle after phase 4. A request waiting there is accepted at the next edge, so back-to-back reads produce rdata_valid pulses exactly 5 cycles apart.
- R9: rdata holds its value in every cycle in which rdata_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core read request present |
| req_addr | input | ADDR_W (20) | Address of the requested read |
| req_ready | output | 1 | Controller idle and able to accept a request |
| rdata | output | DATA_W (16) | Last word read from memory |
| rdata_valid | output | 1 | One-cycle pulse marking a newly returned word |
| mem_addr | output | ADDR_W (20) | External address bus |
| mem_rd_n | output | 1 | External read strobe, active low |
| mem_data | input | DATA_W (16) | External data bus from memory |

## Verification
The hardest case to reach from the ports is showing that the sample point is the strobe-release edge and not one cycle earlier or later. A memory that simply drives its data while the strobe is low cannot reveal a capture one edge early. The bench memory model therefore drives the correct word only in the second strobe-low cycle and a fixed junk pattern in every other cycle, so a capture at any other edge shows up as a data mismatch in the scoreboard.

Two further situations are provoked on purpose:
- Requests are raised with a different address in the middle of a transfer, to show they are ignored.
- Reset is pulled while the strobe is low, to show the bus returns to its idle values at once.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  // Transfer phases; ST_ADDR..ST_DATA are the four bus cycles of one read.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_STROBE = 3'd2,
    ST_WAIT   = 3'd3,
    ST_DATA   = 3'd4
  } rd_phase_e;

  // Strobe level (active low) that belongs to a phase.
  function automatic logic strobe_n_for(input rd_phase_e ph);
    return !((ph == ST_STROBE) || (ph == ST_WAIT));
  endfunction

endpackage

// File: rtl/rdc_seq.sv
module rdc_seq
  import rdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic capture_en,
  output logic rd_n
);

  rd_phase_e state_q;
  rd_phase_e state_d;
  logic      rd_n_q;
  logic      rd_n_d;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign capture_en = (state_q == ST_WAIT);
  assign rd_n       = rd_n_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_ADDR;
      ST_ADDR:   state_d = ST_STROBE;
      ST_STROBE: state_d = ST_WAIT;
      ST_WAIT:   state_d = ST_DATA;
      ST_DATA:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    rd_n_d = strobe_n_for(state_d);
  end

  // State and strobe registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      rd_n_q  <= rd_n_d;
    end
  end

  // R3: once the strobe falls it stays low for one further cycle.
  a_r3_strobe_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);
  // R3: after two low cycles the strobe is released.
  a_r3_strobe_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |=> rd_n);
  // R2: the cycle after acceptance is the address phase with the strobe high.
  a_r2_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rd_n && !req_ready));

endmodule

// File: rtl/rdc_addr_reg.sv
module rdc_addr_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load_en) addr_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_out = addr_q;

  // R2: a loaded address appears on the bus in the next cycle.
  a_r2_addr_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (addr_out == $past(addr_in)));

endmodule

// File: rtl/rdc_data_cap.sv
module rdc_data_cap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] data_out,
  output logic              data_valid
);

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;
  logic              valid_q;

  always_comb begin
    data_d = data_q;
    if (capture_en) data_d = bus_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= capture_en;
    end
  end

  assign data_out   = data_q;
  assign data_valid = valid_q;

  // R6: the valid indication never lasts two cycles.
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  // R9: no new word means the held word does not move.
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> $stable(data_out));

endmodule

// File: rtl/wait_read_ctrl.sv
module wait_read_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_n,
  input  logic [DATA_W-1:0] mem_data
);

  logic accept;
  logic capture_en;

  rdc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .accept     (accept),
    .capture_en (capture_en),
    .rd_n       (mem_rd_n)
  );

  rdc_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (accept),
    .addr_in  (req_addr),
    .addr_out (mem_addr)
  );

  rdc_data_cap #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .bus_data   (mem_data),
    .data_out   (rdata),
    .data_valid (rdata_valid)
  );

  // R4, R7: while busy, the bus address cannot change at the next edge.
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mem_addr));
  // R5: data is taken on the edge that releases the strobe.
  a_r5_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> (rdata_valid && (rdata == $past(mem_data))));
  // R6: the valid pulse comes with the strobe released.
  a_r6_valid_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> mem_rd_n);
  // R8: the cycle after the valid pulse is idle again.
  a_r8_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> req_ready);

endmodule

// File: tb/wait_read_ctrl_tb_top.sv
module wait_read_ctrl_tb_top;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam logic [DW-1:0] JUNK = 16'h7E7E;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_ready;
  logic [DW-1:0] rdata;
  logic          rdata_valid;
  logic [AW-1:0] mem_addr;
  logic          mem_rd_n;
  logic [DW-1:0] mem_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_valid_cyc = -1;
  int last_gap = 0;
  int low_cnt = 0;
  logic [DW-1:0] exp_q[$];

  wait_read_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk, .rst_n, .req_valid, .req_addr, .req_ready, .rdata,
    .rdata_valid, .mem_addr, .mem_rd_n, .mem_data
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: the correct word only in the second strobe-low cycle.
  always @(posedge clk or negedge rst_n)
    if (!rst_n)        low_cnt <= 0;
    else if (mem_rd_n) low_cnt <= 0;
    else               low_cnt <= low_cnt + 1;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a[DW-1:0] ^ 16'hA5C3;
  endfunction

  always_comb mem_data = (!mem_rd_n && low_cnt == 1) ? mem_word(mem_addr) : JUNK;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares returned words with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rdata_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected valid", rdata, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rdata == e, "R5 read data", rdata, e);
        end
        if (last_valid_cyc >= 0) last_gap = cyc - last_valid_cyc;
        last_valid_cyc = cyc;
      end
    end
  end

  // Driver: one read, checks every phase; poke raises a stray request mid-transfer.
  task automatic do_read(input logic [AW-1:0] a, input bit poke);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    exp_q.push_back(mem_word(a));
    @(negedge clk); // phase 1
    req_valid = 1'b0;
    req_addr  = ~a;
    chk(mem_addr == a, "R2 address in phase 1", mem_addr, a);
    chk(mem_rd_n == 1'b1, "R2 strobe high in phase 1", mem_rd_n, 1);
    chk(req_ready == 1'b0, "R7 busy in phase 1", req_ready, 0);
    if (poke) req_valid = 1'b1;
    @(negedge clk); // phase 2
    chk(mem_rd_n == 1'b0, "R3 strobe low in phase 2", mem_rd_n, 0);
    @(negedge clk); // phase 3
    chk(mem_rd_n == 1'b0, "R3 strobe low in phase 3", mem_rd_n, 0);
    chk(mem_addr == a, "R4 address held in phase 3", mem_addr, a);
    req_valid = 1'b0;
    @(negedge clk); // phase 4
    chk(mem_rd_n == 1'b1, "R3 strobe high in phase 4", mem_rd_n, 1);
    chk(rdata_valid == 1'b1, "R6 valid in phase 4", rdata_valid, 1);
    chk(mem_addr == a, "R4 address held in phase 4", mem_addr, a);
    chk(req_ready == 1'b0, "R7 busy in phase 4", req_ready, 0);
    @(negedge clk); // idle again
    chk(rdata_valid == 1'b0, "R6 pulse ended", rdata_valid, 0);
    chk(req_ready == 1'b1, "R8 ready after transfer", req_ready, 1);
    chk(mem_addr == a, "R4 address kept while idle", mem_addr, a);
    chk(rdata == mem_word(a), "R9 data held", rdata, mem_word(a));
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    chk(mem_rd_n == 1'b1, "R1 strobe in reset", mem_rd_n, 1);
    chk(mem_addr == '0, "R1 address in reset", mem_addr, 0);
    chk(rdata_valid == 1'b0 && rdata == '0, "R1 outputs in reset", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_read(20'h12345, 1'b0);
    do_read(20'hFEDCB, 1'b1);   // R7 stray request during transfer
    do_read(20'h00000, 1'b0);
    // R8 back-to-back
    do_read(20'hABCDE, 1'b0);
    do_read(20'h5A5A5, 1'b0);
    chk(last_gap == 5, "R8 back-to-back spacing", last_gap, 5);
    for (int i = 0; i < 6; i++) do_read(AW'(i * 20'h1F3A7 + 3), i[0]);
    do_read(20'hFFFFF, 1'b1);

    // R1 asynchronous reset in the middle of a strobe
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 20'h3C3C3;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(mem_rd_n == 1'b0, "R3 strobe low before reset", mem_rd_n, 0);
    #3 rst_n = 1'b0;
    #1;
    chk(mem_rd_n == 1'b1, "R1 strobe released by reset", mem_rd_n, 1);
    chk(mem_addr == '0, "R1 address cleared by reset", mem_addr, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    last_valid_cyc = -1;
    @(negedge clk);
    chk(rdata_valid == 1'b0, "R1 no valid after aborted read", rdata_valid, 0);
    do_read(20'h0F0F0, 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 every read returned", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule